// File: doc/BRIEF.md
# Acquisition Trigger Sequencer

This block steers an 8-bit sample stream into a sample memory through a single write port. A synchronous arm command latches the configuration and starts an acquisition. An abort command drops the block back to idle at any time. Three capture modes are offered:

- **Start-triggered fill:** one trigger starts storage, which runs until the whole active region is written.
- **Ring capture:** every valid sample is written into a circular region until a trigger ends the run. A programmed number of samples from before the trigger is kept.
- **Multi-segment capture:** every trigger writes one fixed-size segment, and segments are packed back to back.

A trigger counts only in a cycle where the sample is valid. In the start-triggered and multi-segment modes, an optional delay skips a number of valid samples before storage begins. After each segment except the last, a fixed re-arm gap of clock cycles blocks new triggers. All writes are placed at a programmable start address plus an offset. The offset wraps at the end of the active region, and the physical address wraps at the top of memory.

Status outputs report:

- busy and done;
- the number of completed segments;
- the address recorded for the latest accepted trigger, so that ring data can be unrolled in order;
- a sticky flag for triggers that were not accepted.

Top module: `acq_trig_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_we_o, trig_missed_o and seg_cnt_o are all 0.
- R2: arm_i latches every configuration input and makes busy_o 1 in the next cycle. abort_i (which wins over arm_i) returns the block to idle, with busy_o and done_o at 0. An abort blocks the sample of its own cycle and every later sample from being written until the next arm.
- R3: Mode encoding on mode_i is 2'b00 for start-triggered fill (2'b11 acts the same), 2'b01 for ring capture and 2'b10 for multi-segment. In start-triggered fill with delay 0, the trigger sample and the following valid samples are written at base, base+1 and so on, for region_len_i samples in total. done_o then rises and stays high until the next arm or abort.
- R4: With delay_i = D > 0, in start-triggered fill and multi-segment modes, the first D valid samples counted from the trigger sample are discarded. Storage starts with the next valid sample. Cycles with smp_valid_i low are neither counted nor written.
- R5: In ring capture, every valid sample from the cycle after arm is written, at offsets that wrap to 0 at region_len_i. A trigger is accepted only once at least pre_len_i samples have been written since arm. The trigger sample is written, followed by region_len_i - pre_len_i - 1 further samples, and then done_o rises. delay_i has no effect in this mode.
- R6: trig_addr_o holds base plus the offset the accepted trigger would write to. This is the trigger sample's own address in ring capture and for delay 0, and otherwise the address of the first stored sample.
- R7: In multi-segment mode, each accepted trigger writes seg_len_i samples. Segment k starts at offset k*seg_len_i. seg_cnt_o counts finished segments, and done_o rises when seg_num_i segments are finished. Valid samples between segments are not written.
- R8: After each segment that is not the last, the block ignores triggers for exactly REARM_CYC clock cycles following the cycle of its final sample. A trigger in the next cycle is accepted.
- R9: A qualified trigger (trig_i and smp_valid_i both high) that is not accepted sets trig_missed_o. The flag stays set until the next arm.
- R10: The physical write address is (base_addr_i + offset) mod 2^ADDR_W.
- R11: A sample stored in cycle t shows on the write port in cycle t+1, with mem_we_o high and its own data. No other write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start an acquisition, latching the configuration |
| abort_i | input | 1 | Return to idle |
| mode_i | input | 2 | Capture mode (00 fill, 01 ring, 10 segmented) |
| base_addr_i | input | ADDR_W | Start address |
| region_len_i | input | ADDR_W+1 | Active region length in samples |
| seg_len_i | input | ADDR_W+1 | Segment length in samples |
| seg_num_i | input | SEG_W | Number of segments |
| pre_len_i | input | ADDR_W | Samples kept before the trigger in ring capture |
| delay_i | input | DLY_W | Valid samples skipped after a trigger |
| smp_valid_i | input | 1 | Sample valid |
| smp_data_i | input | SMP_W | Sample value |
| trig_i | input | 1 | Trigger, qualified by smp_valid_i |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | SMP_W | Memory write data |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | Acquisition complete |
| seg_cnt_o | output | SEG_W | Finished segments |
| trig_addr_o | output | ADDR_W | Address recorded at the latest accepted trigger |
| trig_missed_o | output | 1 | Sticky flag for a trigger that was not accepted |

## Verification
The bench places a trigger exactly one cycle before and one cycle after the end of the re-arm gap. An off-by-one holdoff counter would either accept the early trigger or lose the later one and its whole segment. In ring capture it triggers one sample short of the pre-trigger count and then exactly on it. A wrong comparison would end the run early or miss the boundary. That test also gives a nonzero delay to show that a design applying the delay there would shift every address. A delayed trigger with a valid-low cycle inside the skip window catches a delay counter that counts clocks instead of samples, and a start address near the top of memory catches an address that fails to wrap. An abort arriving together with a valid sample catches a design that still writes that sample or keeps running.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    MODE_FILL = 2'b00,
    MODE_RING = 2'b01,
    MODE_SEG  = 2'b10,
    MODE_ALT  = 2'b11
  } acq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_DELAY = 3'd2,
    ST_STORE = 3'd3,
    ST_REARM = 3'd4,
    ST_DONE  = 3'd5
  } acq_state_e;
endpackage

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
  parameter int ADDR_W = 12,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  rlen_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] off_q;
  logic [CNT_W-1:0]  off_inc;

  assign off_inc = {1'b0, off_q} + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (clr_i)  off_q <= '0;
    else if (step_i) off_q <= (off_inc == rlen_i) ? '0 : off_inc[ADDR_W-1:0];
  end

  assign addr_o = base_i + off_q;

  AST_OFF_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rlen_i != '0) |-> ({1'b0, off_q} < rlen_i)); // R5
endmodule

// File: rtl/acq_span_ctr.sv
module acq_span_ctr #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         one_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign one_o = (cnt_q == W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/acq_holdoff.sv
module acq_holdoff #(
  parameter int CYC = 38,
  localparam int HW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic last_o
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (start_i)       cnt_q <= HW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - HW'(1);
  end

  assign last_o = (cnt_q == HW'(1));

  AST_HOLD_RUNS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i && !clr_i) |=> (cnt_q == $past(cnt_q) - HW'(1))); // R8
endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
  import acq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DLY_W     = 20,
  parameter int SEG_W     = 8,
  parameter int SMP_W     = 8,
  parameter int REARM_CYC = 38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              abort_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W:0]   region_len_i,
  input  logic [ADDR_W:0]   seg_len_i,
  input  logic [SEG_W-1:0]  seg_num_i,
  input  logic [ADDR_W-1:0] pre_len_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  input  logic              trig_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SMP_W-1:0]  mem_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEG_W-1:0]  seg_cnt_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output logic              trig_missed_o
);
  localparam int CNT_W = ADDR_W + 1;

  acq_state_e        state_q, state_d;
  acq_mode_e         mode_q;
  logic [ADDR_W-1:0] base_q, pre_q;
  logic [CNT_W-1:0]  rlen_q, slen_q;
  logic [SEG_W-1:0]  snum_q, seg_cnt_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  pre_seen_q;

  logic              is_ring, is_seg, pre_ok, trig_ev, accept;
  logic              dly_zero, dly_one, store_now, end_seg, more_seg, ctl;
  logic [CNT_W-1:0]  seg_len_eff, post_n, rem_load;
  logic [SEG_W:0]    seg_next;
  logic              rem_one, dly_last, hold_last;
  logic [ADDR_W-1:0] cur_addr;

  assign ctl      = arm_i | abort_i;
  assign is_ring  = (mode_q == MODE_RING);
  assign is_seg   = (mode_q == MODE_SEG);
  assign dly_zero = (dly_q == '0);
  assign dly_one  = (dly_q == DLY_W'(1));
  assign pre_ok   = (pre_seen_q >= {1'b0, pre_q});
  assign trig_ev  = trig_i & smp_valid_i;
  assign accept   = trig_ev & (state_q == ST_ARMED) & (!is_ring | pre_ok);

  assign seg_len_eff = is_seg ? slen_q : rlen_q;
  assign post_n      = rlen_q - {1'b0, pre_q} - CNT_W'(1);
  assign seg_next    = {1'b0, seg_cnt_q} + (SEG_W+1)'(1);
  assign more_seg    = is_seg & (seg_next < {1'b0, snum_q});

  // samples that reach memory this cycle
  assign store_now = smp_valid_i & ((state_q == ST_STORE) |
                                    ((state_q == ST_ARMED) & is_ring) |
                                    (accept & dly_zero));

  always_comb begin
    end_seg = 1'b0;
    if (state_q == ST_ARMED && accept)
      end_seg = is_ring ? (post_n == '0) : (dly_zero && seg_len_eff == CNT_W'(1));
    else if (state_q == ST_STORE)
      end_seg = smp_valid_i & rem_one;
  end

  always_comb begin
    if (is_ring)       rem_load = post_n;
    else if (dly_zero) rem_load = seg_len_eff - CNT_W'(1);
    else               rem_load = seg_len_eff;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: begin
        if (accept) begin
          if (end_seg)                          state_d = more_seg ? ST_REARM : ST_DONE;
          else if (is_ring || dly_zero || dly_one) state_d = ST_STORE;
          else                                  state_d = ST_DELAY;
        end
      end
      ST_DELAY: if (smp_valid_i && dly_last) state_d = ST_STORE;
      ST_STORE: if (end_seg) state_d = more_seg ? ST_REARM : ST_DONE;
      ST_REARM: if (hold_last) state_d = ST_ARMED;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ST_IDLE;
    else if (abort_i) state_q <= ST_IDLE;
    else if (arm_i)   state_q <= ST_ARMED;
    else              state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FILL;
      base_q <= '0;
      pre_q  <= '0;
      rlen_q <= '0;
      slen_q <= '0;
      snum_q <= '0;
      dly_q  <= '0;
    end else if (arm_i && !abort_i) begin
      mode_q <= acq_mode_e'(mode_i);
      base_q <= base_addr_i;
      pre_q  <= pre_len_i;
      rlen_q <= region_len_i;
      slen_q <= seg_len_i;
      snum_q <= seg_num_i;
      dly_q  <= delay_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pre_seen_q <= '0;
    else if (arm_i)
      pre_seen_q <= '0;
    else if (store_now && state_q == ST_ARMED && is_ring && !pre_ok && !abort_i)
      pre_seen_q <= pre_seen_q + CNT_W'(1);
  end

  acq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .step_i (store_now & ~ctl),
    .base_i (base_q),
    .rlen_i (rlen_q),
    .addr_o (cur_addr)
  );

  acq_span_ctr #(.W(CNT_W)) u_rem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept & ~ctl),
    .load_val_i (rem_load),
    .dec_i      ((state_q == ST_STORE) & smp_valid_i & ~ctl),
    .one_o      (rem_one)
  );

  acq_span_ctr #(.W(DLY_W)) u_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept & ~ctl),
    .load_val_i (dly_q - DLY_W'(1)),
    .dec_i      ((state_q == ST_DELAY) & smp_valid_i & ~ctl),
    .one_o      (dly_last)
  );

  acq_holdoff #(.CYC(REARM_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctl),
    .start_i (end_seg & more_seg),
    .last_o  (hold_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= store_now & ~ctl;
      if (store_now) begin
        mem_addr_o <= cur_addr;
        mem_data_o <= smp_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_cnt_q     <= '0;
      trig_addr_o   <= '0;
      trig_missed_o <= 1'b0;
    end else if (arm_i && !abort_i) begin
      seg_cnt_q     <= '0;
      trig_missed_o <= 1'b0;
    end else begin
      if (end_seg && !abort_i) seg_cnt_q   <= seg_next[SEG_W-1:0];
      if (accept && !abort_i)  trig_addr_o <= cur_addr;
      if (trig_ev && !accept)  trig_missed_o <= 1'b1;
    end
  end

  assign seg_cnt_o = seg_cnt_q;
  assign busy_o    = (state_q == ST_ARMED) | (state_q == ST_DELAY) |
                     (state_q == ST_STORE) | (state_q == ST_REARM);
  assign done_o    = (state_q == ST_DONE);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !mem_we_o); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i && !abort_i) |=> done_o); // R3
  AST_DELAY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY) |=> !mem_we_o); // R4
  AST_SEG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(arm_i) && seg_cnt_o != $past(seg_cnt_o)) |->
      (seg_cnt_o == SEG_W'($past(seg_cnt_o) + 1'b1))); // R7
  AST_GAP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REARM) |=> !mem_we_o); // R8
  AST_MISS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_missed_o && !arm_i) |=> trig_missed_o); // R9
  AST_WR_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1) || mem_addr_o == base_q)); // R10
endmodule

// File: tb/acq_trig_seq_test.sv
`timescale 1ns/1ps
module acq_trig_seq_test;
  localparam int AW = 12;
  localparam int DW = 20;
  localparam int SW = 8;
  localparam int REARM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0, abort_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [AW-1:0] base_addr_i = '0, pre_len_i = '0;
  logic [AW:0] region_len_i = '0, seg_len_i = '0;
  logic [SW-1:0] seg_num_i = '0;
  logic [DW-1:0] delay_i = '0;
  logic smp_valid_i = 1'b0, trig_i = 1'b0;
  logic [7:0] smp_data_i = '0;
  logic mem_we_o, busy_o, done_o, trig_missed_o;
  logic [AW-1:0] mem_addr_o, trig_addr_o;
  logic [7:0] mem_data_o;
  logic [SW-1:0] seg_cnt_o;

  always #2 clk = ~clk;

  acq_trig_seq #(.ADDR_W(AW), .DLY_W(DW), .SEG_W(SW), .SMP_W(8), .REARM_CYC(REARM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm_i), .abort_i(abort_i), .mode_i(mode_i),
    .base_addr_i(base_addr_i), .region_len_i(region_len_i), .seg_len_i(seg_len_i),
    .seg_num_i(seg_num_i), .pre_len_i(pre_len_i), .delay_i(delay_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .trig_i(trig_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .busy_o(busy_o), .done_o(done_o), .seg_cnt_o(seg_cnt_o),
    .trig_addr_o(trig_addr_o), .trig_missed_o(trig_missed_o)
  );

  int total = 0;
  int bad = 0;
  int q_a[$];
  int q_d[$];
  string q_t[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_wr(input int a, input int d, input string tag);
    q_a.push_back(a % (1 << AW));
    q_d.push_back(d & 8'hff);
    q_t.push_back(tag);
  endtask

  task automatic step(input bit v, input int d, input bit t);
    smp_valid_i = v;
    smp_data_i  = 8'(d);
    trig_i      = t;
    @(negedge clk);
  endtask

  task automatic setup(input int mode, input int base, input int rlen, input int slen,
                       input int snum, input int pre, input int dly);
    mode_i = 2'(mode); base_addr_i = AW'(base); region_len_i = (AW+1)'(rlen);
    seg_len_i = (AW+1)'(slen); seg_num_i = SW'(snum); pre_len_i = AW'(pre);
    delay_i = DW'(dly);
  endtask

  task automatic do_arm();
    arm_i = 1'b1;
    step(0, 0, 0);
    arm_i = 1'b0;
  endtask

  // monitor: every write must match the head of the scoreboard (R11)
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (q_a.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R11 unexpected write actual=%0d expected=none",
                 int'(mem_addr_o) * 256 + int'(mem_data_o));
      end else begin
        int ea, ed;
        string et;
        ea = q_a.pop_front();
        ed = q_d.pop_front();
        et = q_t.pop_front();
        chk(mem_addr_o == AW'(ea) && mem_data_o == 8'(ed), et,
            int'(mem_addr_o) * 256 + int'(mem_data_o), ea * 256 + ed);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    chk(!mem_we_o, "R1 we", mem_we_o, 0);
    chk(!trig_missed_o, "R1 missed", trig_missed_o, 0);
    chk(seg_cnt_o == 0, "R1 segcnt", seg_cnt_o, 0);

    // start-triggered fill, delay 0, gap in the stream
    setup(0, 100, 8, 0, 0, 0, 0);
    do_arm();
    chk(busy_o, "R2 busy after arm", busy_o, 1);
    repeat (3) step(1, 8'h30, 0);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) step(0, 8'hee, 0);
      expect_wr(100 + i, 8'h40 + i, "R3 fill");
      step(1, 8'h40 + i, i == 0);
    end
    chk(done_o, "R3 done", done_o, 1);
    chk(!busy_o, "R3 busy", busy_o, 0);
    chk(trig_addr_o == 100, "R6 fill", trig_addr_o, 100);
    chk(seg_cnt_o == 1, "R7 single", seg_cnt_o, 1);
    step(1, 8'h55, 1);
    chk(trig_missed_o, "R9 late trigger", trig_missed_o, 1);
    chk(done_o, "R3 done holds", done_o, 1);

    // delayed trigger with top-of-memory wrap
    setup(0, 4094, 5, 0, 0, 0, 3);
    do_arm();
    chk(!trig_missed_o, "R9 cleared by arm", trig_missed_o, 0);
    step(1, 8'h10, 1);
    step(1, 8'h11, 0);
    step(0, 8'hee, 0);
    step(1, 8'h12, 0);
    for (int i = 0; i < 5; i++) begin
      expect_wr(4094 + i, 8'h13 + i, "R10 wrap/R4 delay");
      step(1, 8'h13 + i, 0);
    end
    chk(done_o, "R4 done", done_o, 1);
    chk(trig_addr_o == 4094, "R6 delayed", trig_addr_o, 4094);

    // ring capture with wrap; delay must have no effect
    setup(1, 200, 16, 0, 0, 5, 7);
    do_arm();
    for (int i = 0; i < 31; i++) begin
      expect_wr(200 + (i % 16), 8'h80 + i, "R5 ring");
      step(1, 8'h80 + i, i == 2 || i == 20);
      if (i == 2) chk(trig_missed_o, "R9 early ring trigger", trig_missed_o, 1);
    end
    chk(done_o, "R5 ring done", done_o, 1);
    chk(trig_addr_o == 204, "R6 ring", trig_addr_o, 204);

    // ring capture, trigger exactly at the pre-count boundary
    setup(1, 300, 8, 0, 0, 5, 0);
    do_arm();
    for (int i = 0; i < 8; i++) begin
      expect_wr(300 + i, 8'h60 + i, "R5 boundary");
      step(1, 8'h60 + i, i == 4 || i == 5);
      if (i == 4) chk(busy_o && !done_o, "R5 one short rejected", busy_o, 1);
    end
    chk(done_o, "R5 boundary done", done_o, 1);
    chk(trig_addr_o == 305, "R6 boundary", trig_addr_o, 305);

    // abort during storage
    setup(0, 0, 20, 0, 0, 0, 0);
    do_arm();
    expect_wr(0, 1, "R2 before abort");
    step(1, 1, 1);
    expect_wr(1, 2, "R2 before abort");
    step(1, 2, 0);
    abort_i = 1'b1;
    step(1, 3, 0);
    abort_i = 1'b0;
    chk(!busy_o, "R2 abort busy", busy_o, 0);
    chk(!done_o, "R2 abort done", done_o, 0);
    step(1, 4, 1);
    step(1, 5, 0);

    // multi-segment with re-arm gap
    setup(2, 1000, 64, 4, 3, 0, 0);
    do_arm();
    for (int i = 0; i < 4; i++) begin
      expect_wr(1000 + i, 8'h20 + i, "R7 seg0");
      step(1, 8'h20 + i, i == 0);
    end
    chk(seg_cnt_o == 1, "R7 count 1", seg_cnt_o, 1);
    chk(busy_o && !done_o, "R7 still busy", busy_o, 1);
    chk(!trig_missed_o, "R8 flag before gap trigger", trig_missed_o, 0);
    repeat (REARM - 1) step(0, 0, 0);
    step(1, 8'h99, 1);
    chk(trig_missed_o, "R8 gap trigger ignored", trig_missed_o, 1);
    for (int i = 0; i < 4; i++) begin
      expect_wr(1004 + i, 8'h30 + i, "R8 seg1 after gap");
      step(1, 8'h30 + i, i == 0);
    end
    chk(seg_cnt_o == 2, "R7 count 2", seg_cnt_o, 2);
    repeat (20) step(1, 8'h77, 0);
    for (int i = 0; i < 4; i++) begin
      expect_wr(1008 + i, 8'h40 + i, "R7 seg2");
      step(1, 8'h40 + i, i == 0);
    end
    chk(done_o, "R7 done", done_o, 1);
    chk(seg_cnt_o == 3, "R7 count 3", seg_cnt_o, 3);
    chk(trig_addr_o == 1008, "R6 seg", trig_addr_o, 1008);

    repeat (3) step(0, 0, 0);
    chk(q_a.size() == 0, "R11 all writes seen", q_a.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule